// File: doc/BRIEF.md
# Row-by-Row LCD Refresh Controller with CPU Halt Handshake

This block keeps a monochrome bitmap panel refreshed from shared system RAM. A free-running timebase in the crystal clock domain marks a row start at a fixed period. At each row start the block raises a halt request to the processor. Once the processor acknowledges, the block reads the row's words from RAM and releases the request. It then serialises the row's pixels to the column drivers and strobes a row latch. Because the processor is simply stopped and resumed, its registers need no save or restore.

Software sees a line counter that tells it which row the panel will drive next. No event or interrupt marks the end of a frame, so software must poll this counter or use a timer of its own. A frame base address selects where the bitmap lives in RAM. It is taken only when row 0 is fetched, so a new base written in the middle of a frame never splits the picture. An enable input stops all refresh activity. A contrast register passes a value to the analog panel drive.

Top module: `lcd_row_refresh`

## Requirements
- R1: While `disp_en` is high, row fetches begin exactly `ROW_PERIOD` crystal clock cycles apart, so consecutive rising edges of `halt_req` are `ROW_PERIOD` cycles apart.
- R2: `line_count` is 0 after reset. It advances by one, modulo `ROWS`, in the same cycle that `halt_req` rises for a row. It then holds the number of the row to be fetched after the current one. Going from `ROWS-1` back to 0 produces no signal other than the counter value.
- R3: `ram_rd` is never high while `halt_ack` is low. `halt_req` stays high for exactly one cycle after the last read of a row, and then goes low.
- R4: Each row issues `WORDS` reads, one per cycle, to addresses `frame_base + row*WORDS + k` for k = 0 up to `WORDS-1`, in ascending order. Read data returns on `ram_rdata` one cycle after the read.
- R5: `frame_base` takes the value of `base_addr` only at the start of a row-0 fetch. A change to `base_addr` during a frame has no effect until the next frame.
- R6: After a row's reads, `WORDS*WORD_W` consecutive cycles have `pix_clk` high. `pix_data` carries word 0 first, and the bits of each word go out least significant bit first. `row_latch` is high for one cycle directly after the last pixel.
- R7: While `disp_en` is low, `halt_req`, `ram_rd` and `pix_clk` stay low and `line_count` holds its value. If `disp_en` falls during a row fetch, `halt_req` and `ram_rd` are low from the next cycle.
- R8: `contrast_out` is 0 after reset. It takes `contrast_in` on the cycle after `contrast_we` is high, and otherwise holds its value whatever `contrast_in` does.
- R9: During and right after reset, `halt_req`, `ram_rd`, `pix_clk` and `row_latch` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_en | input | 1 | Display refresh enable |
| base_addr | input | AW | Bitmap base address, taken at the start of each frame |
| contrast_in | input | CW | Contrast write data |
| contrast_we | input | 1 | Contrast write strobe |
| halt_ack | input | 1 | Processor acknowledge that it has halted |
| ram_rdata | input | WORD_W | RAM read data, one cycle after the read |
| halt_req | output | 1 | Halt request to the processor |
| ram_rd | output | 1 | RAM read strobe |
| ram_addr | output | AW | RAM read address |
| line_count | output | LW | Next row to be fetched |
| pix_data | output | 1 | Serial pixel data |
| pix_clk | output | 1 | Pixel valid strobe |
| row_latch | output | 1 | Row latch strobe after the last pixel |
| contrast_out | output | CW | Contrast value to the panel drive |

## Verification
`halt_req` and the new `line_count` appear one cycle after the timebase fires. The first read follows one cycle after `halt_ack` is seen, and the reads then run back to back. `halt_req` falls two cycles after the last read. The pixel burst begins three cycles after the last read, and the latch follows in the cycle after the last pixel. The bench samples every output on the falling edge. It finds each row by the rise of `halt_req`, measures the period from one rise to the next, and from there walks forward cycle by cycle, demanding each event in its exact cycle instead of waiting for it. The disable, abort and contrast tests check their result at a fixed one-cycle delay, or over a window of several row periods.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
  typedef enum logic [1:0] {F_IDLE, F_REQ, F_READ, F_CAPT} fetch_st_e;
  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_LATCH} shift_st_e;
endpackage

// File: rtl/lcd_timebase.sv
module lcd_timebase #(
  parameter int ROW_PERIOD = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic row_start
);
  localparam int TW = (ROW_PERIOD > 2) ? $clog2(ROW_PERIOD) : 1;
  logic [TW-1:0] tick_q, tick_d;

  assign row_start = en && (tick_q == TW'(ROW_PERIOD - 1));

  always_comb begin
    if (!en)           tick_d = '0;
    else if (row_start) tick_d = '0;
    else               tick_d = tick_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= '0;
    else        tick_q <= tick_d;
  end
endmodule

// File: rtl/lcd_fetch.sv
module lcd_fetch
  import lcd_pkg::*;
#(
  parameter int ROWS   = 64,
  parameter int WORDS  = 2,
  parameter int WORD_W = 8,
  parameter int AW     = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    row_start,
  input  logic [AW-1:0]           base_addr,
  input  logic                    halt_ack,
  input  logic [WORD_W-1:0]       ram_rdata,
  output logic                    halt_req,
  output logic                    ram_rd,
  output logic [AW-1:0]           ram_addr,
  output logic [$clog2(ROWS)-1:0] line_count,
  output logic                    row_load,
  output logic [WORDS*WORD_W-1:0] row_bits
);
  localparam int LW  = $clog2(ROWS);
  localparam int WIW = (WORDS > 1) ? $clog2(WORDS) : 1;

  fetch_st_e       st_q, st_d;
  logic [LW-1:0]   line_q, line_d, frow_q, frow_d;
  logic [AW-1:0]   fbase_q, fbase_d;
  logic [WIW-1:0]  widx_q, widx_d, cidx_q;
  logic            cap_q, load_q;
  logic [WORDS*WORD_W-1:0] row_q;

  always_comb begin
    st_d    = st_q;
    line_d  = line_q;
    frow_d  = frow_q;
    fbase_d = fbase_q;
    widx_d  = widx_q;
    if (!en) begin
      st_d = F_IDLE;
    end else begin
      case (st_q)
        F_IDLE: if (row_start) begin
          st_d   = F_REQ;
          frow_d = line_q;
          line_d = (line_q == LW'(ROWS - 1)) ? '0 : line_q + 1'b1;
          if (line_q == '0) fbase_d = base_addr;
        end
        F_REQ: if (halt_ack) begin
          st_d   = F_READ;
          widx_d = '0;
        end
        F_READ: begin
          if (widx_q == WIW'(WORDS - 1)) st_d = F_CAPT;
          else                           widx_d = widx_q + 1'b1;
        end
        default: st_d = F_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= F_IDLE;
      line_q  <= '0;
      frow_q  <= '0;
      fbase_q <= '0;
      widx_q  <= '0;
    end else begin
      st_q    <= st_d;
      line_q  <= line_d;
      frow_q  <= frow_d;
      fbase_q <= fbase_d;
      widx_q  <= widx_d;
    end
  end

  // capture path: data returns one cycle after each read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= 1'b0;
      cidx_q <= '0;
      load_q <= 1'b0;
      row_q  <= '0;
    end else begin
      cap_q  <= ram_rd;
      cidx_q <= widx_q;
      load_q <= en && (st_q == F_CAPT);
      if (cap_q) row_q[int'(cidx_q)*WORD_W +: WORD_W] <= ram_rdata;
    end
  end

  assign halt_req   = (st_q == F_REQ) || (st_q == F_READ) || (st_q == F_CAPT);
  assign ram_rd     = (st_q == F_READ);
  assign ram_addr   = fbase_q + AW'(frow_q) * AW'(WORDS) + AW'(widx_q);
  assign line_count = line_q;
  assign row_load   = load_q;
  assign row_bits   = row_q;
endmodule

// File: rtl/lcd_shifter.sv
module lcd_shifter
  import lcd_pkg::*;
#(
  parameter int PIX = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [PIX-1:0] row_bits,
  output logic           pix_data,
  output logic           pix_clk,
  output logic           row_latch
);
  localparam int CW = (PIX > 2) ? $clog2(PIX) : 1;

  shift_st_e      st_q, st_d;
  logic [PIX-1:0] sr_q, sr_d;
  logic [CW-1:0]  cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    sr_d  = sr_q;
    cnt_d = cnt_q;
    case (st_q)
      S_IDLE: if (load) begin
        st_d  = S_SHIFT;
        sr_d  = row_bits;
        cnt_d = CW'(PIX - 1);
      end
      S_SHIFT: begin
        sr_d = sr_q >> 1;
        if (cnt_q == '0) st_d = S_LATCH;
        else             cnt_d = cnt_q - 1'b1;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
    end
  end

  assign pix_clk   = (st_q == S_SHIFT);
  assign pix_data  = pix_clk && sr_q[0];
  assign row_latch = (st_q == S_LATCH);
endmodule

// File: rtl/lcd_row_refresh.sv
module lcd_row_refresh #(
  parameter int ROWS       = 64,
  parameter int ROW_PERIOD = 40,
  parameter int WORDS      = 2,
  parameter int WORD_W     = 8,
  parameter int AW         = 12,
  parameter int CW         = 5,
  parameter int LW         = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_en,
  input  logic [AW-1:0]     base_addr,
  input  logic [CW-1:0]     contrast_in,
  input  logic              contrast_we,
  input  logic              halt_ack,
  input  logic [WORD_W-1:0] ram_rdata,
  output logic              halt_req,
  output logic              ram_rd,
  output logic [AW-1:0]     ram_addr,
  output logic [LW-1:0]     line_count,
  output logic              pix_data,
  output logic              pix_clk,
  output logic              row_latch,
  output logic [CW-1:0]     contrast_out
);
  localparam int PIX = WORDS * WORD_W;

  logic           row_start, row_load;
  logic [PIX-1:0] row_bits;
  logic [CW-1:0]  contr_q, contr_d;

  lcd_timebase #(.ROW_PERIOD(ROW_PERIOD)) u_tb (
    .clk(clk), .rst_n(rst_n), .en(disp_en), .row_start(row_start)
  );

  lcd_fetch #(.ROWS(ROWS), .WORDS(WORDS), .WORD_W(WORD_W), .AW(AW)) u_fetch (
    .clk(clk), .rst_n(rst_n), .en(disp_en), .row_start(row_start),
    .base_addr(base_addr), .halt_ack(halt_ack), .ram_rdata(ram_rdata),
    .halt_req(halt_req), .ram_rd(ram_rd), .ram_addr(ram_addr),
    .line_count(line_count), .row_load(row_load), .row_bits(row_bits)
  );

  lcd_shifter #(.PIX(PIX)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(row_load), .row_bits(row_bits),
    .pix_data(pix_data), .pix_clk(pix_clk), .row_latch(row_latch)
  );

  assign contr_d = contrast_we ? contrast_in : contr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) contr_q <= '0;
    else        contr_q <= contr_d;
  end

  assign contrast_out = contr_q;
endmodule

// File: rtl/lcd_row_refresh_chk.sv
module lcd_row_refresh_chk #(
  parameter int ROWS = 64,
  parameter int LW   = 6,
  parameter int CW   = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          disp_en,
  input logic          halt_ack,
  input logic          halt_req,
  input logic          ram_rd,
  input logic [LW-1:0] line_count,
  input logic          pix_clk,
  input logic          row_latch,
  input logic [CW-1:0] contrast_in,
  input logic          contrast_we,
  input logic [CW-1:0] contrast_out
);
  p_rd_needs_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ram_rd |-> halt_ack);

  p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_rd && disp_en) ##1 (!ram_rd && disp_en) |-> halt_req ##1 !halt_req);

  p_line_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(line_count) |->
      (line_count == (($past(line_count) == LW'(ROWS - 1)) ? '0 : $past(line_count) + 1'b1)));

  p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_en |=> (!halt_req && !ram_rd));

  p_latch_after_pix_r6: assert property (@(posedge clk) disable iff (!rst_n)
    row_latch |-> ($past(pix_clk) && !pix_clk));

  p_contrast_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(contrast_we) |-> $stable(contrast_out));

  p_contrast_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(contrast_we) |-> (contrast_out == $past(contrast_in)));
endmodule

bind lcd_row_refresh lcd_row_refresh_chk #(.ROWS(ROWS), .LW(LW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_en(disp_en), .halt_ack(halt_ack),
  .halt_req(halt_req), .ram_rd(ram_rd), .line_count(line_count),
  .pix_clk(pix_clk), .row_latch(row_latch), .contrast_in(contrast_in),
  .contrast_we(contrast_we), .contrast_out(contrast_out)
);

// File: tb/lcd_row_refresh_test.sv
module lcd_row_refresh_test;
  localparam int ROWS = 64, RP = 40, WORDS = 2, WW = 8, AW = 12, CW = 5;
  localparam int LW = 6, PIX = WORDS * WW;
  localparam int NV = 8;
  // each entry: {ack delay[1:0], base address[11:0]}
  localparam logic [13:0] VEC [NV] = '{
    {2'd0, 12'h100}, {2'd1, 12'h300}, {2'd2, 12'h7A0}, {2'd3, 12'h010},
    {2'd0, 12'hC40}, {2'd2, 12'h5F0}, {2'd1, 12'h222}, {2'd3, 12'h9E0}};

  logic clk = 1'b0, rst_n = 1'b0, disp_en = 1'b0, contrast_we = 1'b0;
  logic halt_ack = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [CW-1:0] contrast_in = '0;
  logic [WW-1:0] ram_rdata = '0;
  logic halt_req, ram_rd, pix_data, pix_clk, row_latch;
  logic [AW-1:0] ram_addr;
  logic [LW-1:0] line_count;
  logic [CW-1:0] contrast_out;

  int errors = 0, checks = 0, cyc = 0, ack_dly = 0, acnt = 0;

  lcd_row_refresh uut (.*);

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [WW-1:0] memf(input logic [AW-1:0] a);
    return WW'(a * 37 + 5);
  endfunction

  // RAM with one-cycle read latency; processor that acknowledges after ack_dly cycles
  always @(posedge clk) begin
    if (ram_rd) ram_rdata <= memf(ram_addr);
    if (!halt_req) begin halt_ack <= 1'b0; acnt <= 0; end
    else if (acnt >= ack_dly) halt_ack <= 1'b1;
    else acnt <= acnt + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R1: watchdog expired actual=running expected=done");
    summary();
  end

  int last_rise = -1;
  logic [AW-1:0] exp_base = '0;

  task automatic do_row(input int row, input bit meas);
    int found = 0, k = 0, t = 0, w = 0;
    for (int i = 0; i < 3 * RP; i++) begin
      @(negedge clk);
      if (halt_req) begin found = 1; break; end
    end
    chk("R1 row start seen", found, 1);
    if (meas) chk("R1 row period", cyc - last_rise, RP);
    last_rise = cyc;
    chk("R2 line count", line_count, (row + 1) % ROWS);
    if (row == 0) exp_base = base_addr;
    for (int i = 0; i < 12 && k < WORDS; i++) begin
      if (i > 0) @(negedge clk);
      if (ram_rd) begin
        chk("R3 read only with ack", halt_ack, 1);
        chk("R4 R5 read address", ram_addr, exp_base + AW'(row * WORDS + k));
        k++;
      end
    end
    chk("R4 read count", k, WORDS);
    @(negedge clk);
    chk("R3 req held after last read", {halt_req, ram_rd}, 2'b10);
    @(negedge clk);
    chk("R3 req released", halt_req, 0);
    for (int i = 0; i < 6 && !pix_clk; i++) @(negedge clk);
    for (int p = 0; p < PIX; p++) begin
      w = memf(exp_base + AW'(row * WORDS + p / WW));
      t = w >> (p % WW);
      if (!pix_clk || pix_data !== t[0]) begin
        chk("R6 pixel", {pix_clk, pix_data}, {1'b1, t[0]});
      end else checks++;
      @(negedge clk);
    end
    chk("R6 row latch after last pixel", {row_latch, pix_clk}, 2'b10);
    @(negedge clk);
    chk("R6 latch one cycle", row_latch, 0);
  endtask

  initial begin
    #1;
    @(negedge clk);
    chk("R9 reset outputs", {halt_req, ram_rd, pix_clk, row_latch}, 4'b0);
    chk("R2 line count reset", line_count, 0);
    chk("R8 contrast reset", contrast_out, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R9 outputs after release", {halt_req, ram_rd, pix_clk, row_latch}, 4'b0);

    // table walk: two full frames plus a few rows, base changing every row
    base_addr = VEC[0][11:0]; ack_dly = int'(VEC[0][13:12]);
    disp_en = 1'b1;
    for (int ev = 0; ev < 2 * ROWS + 4; ev++) begin
      do_row(ev % ROWS, ev > 0);
      base_addr = VEC[(ev + 1) % NV][11:0];
      ack_dly   = int'(VEC[(ev + 1) % NV][13:12]);
    end

    // R7: disabled for several periods, nothing happens
    begin
      int act = 0;
      logic [LW-1:0] lc;
      @(negedge clk); disp_en = 1'b0; lc = line_count;
      for (int i = 0; i < 3 * RP; i++) begin
        @(negedge clk);
        if (halt_req || ram_rd || pix_clk) act++;
      end
      chk("R7 idle when disabled", act, 0);
      chk("R7 line count holds", line_count, lc);
    end

    // R7: drop enable while waiting for a slow acknowledge
    ack_dly = 3;
    disp_en = 1'b1;
    for (int i = 0; i < 2 * RP && !halt_req; i++) @(negedge clk);
    chk("R7 row started", halt_req, 1);
    disp_en = 1'b0;
    @(negedge clk);
    chk("R7 abort releases req", {halt_req, ram_rd}, 2'b00);

    // R8 contrast register
    contrast_in = 5'h15; contrast_we = 1'b1;
    @(negedge clk); contrast_we = 1'b0;
    chk("R8 contrast load", contrast_out, 5'h15);
    contrast_in = 5'h0A;
    repeat (2) @(negedge clk);
    chk("R8 contrast hold", contrast_out, 5'h15);

    // R9 reset in mid-run
    disp_en = 1'b1;
    repeat (RP + 3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 reset mid-run", {halt_req, ram_rd, pix_clk, row_latch}, 4'b0);
    chk("R2 line count cleared", line_count, 0);
    chk("R8 contrast cleared", contrast_out, 0);
    summary();
  end
endmodule